// File: doc/BRIEF.md
# Dual-Tone Burst Pulse Generator

This block drives a transducer pad with a finite burst of square pulses. When it is idle it holds the pad at a chosen pause condition: driven high, driven low, or released to high impedance. When a trigger is accepted, it plays up to three pulse groups back to back, in this order:

- a lead group timed by the first high/low period pair;
- a main group timed by the second pair;
- a short tail that keeps the main group's timing but with the two levels swapped, which is a half-cycle phase shift.

After the tail the pad goes back to its pause condition and a one-cycle completion strobe fires.

Configuration is written through a narrow register port. The trigger comes either from a command write or from an external sequencer pin. The reported channel comes either from a register bit or from a sequencer pin. A stop command ends a burst at once. Registers are read live, so software should change them only while the block is idle. The enable bit gates whether a trigger starts anything.

The register map uses 16-bit write data:

| Address | Contents |
|---|---|
| 0 | Control |
| 1 | Lead count |
| 2 | Main count and tail count |
| 3 | Lead high period |
| 4 | Lead low period |
| 5 | Main high period |
| 6 | Main low period |
| 7 | Command; nothing is stored |

Top module: `burst_pulse_gen`

## Requirements
- R1: After reset, busy_o and done_o are 0, pad_oe_o is 1, pad_o is 0 and chan_o is 0.
- R2: On an accepted trigger the pulse groups run in a fixed order: lead, main, tail. Lead count is in address 1 bits [6:0]. Main count is in address 2 bits [6:0]. Tail count is in address 2 bits [11:8]. A group with count 0 is skipped with no idle cycles. The first level appears in the cycle that follows the clock edge that sampled the trigger.
- R3: Within a pulse, the high level lasts the high period and the low level lasts the low period, in clock cycles. The lead group uses addresses 3 (high) and 4 (low). The main and tail groups use addresses 5 (high) and 6 (low). A period of 0 behaves as 1.
- R4: Control bit 4 sets polarity. When it is 0, each lead and main pulse starts high. When it is 1, each such pulse starts low. Tail pulses always start at the opposite level to main pulses.
- R5: While idle, control bit 6 (hi-Z) set gives pad_oe_o=0 and pad_o=0. With bit 6 clear, pad_oe_o=1 and pad_o equals control bit 5. During a burst pad_oe_o is 1.
- R6: With control bit 1 clear, a write of address 7 with bit 0 set triggers a burst. With control bit 1 set, seq_trig_i triggers a burst and the command trigger has no effect.
- R7: With control bit 0 (enable) clear, no trigger starts a burst.
- R8: A write of address 7 with bit 1 set aborts any burst. From the next cycle the pad shows the pause condition, busy_o is 0, and no done_o pulse is produced.
- R9: busy_o is 1 from the cycle after the trigger until the burst ends. Triggers that arrive while busy leave the burst unchanged.
- R10: done_o is 1 for exactly one cycle, the cycle after the last level of a burst that ends normally. If all three counts are 0, done_o is 1 in the cycle after the trigger and busy_o stays 0.
- R11: chan_o equals control bit 3 when control bit 2 is 0, and equals seq_chan_i when control bit 2 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| seq_trig_i | input | 1 | Sequencer trigger |
| seq_chan_i | input | 1 | Sequencer channel choice |
| pad_o | output | 1 | Pad level |
| pad_oe_o | output | 1 | Pad drive enable; 0 means high impedance |
| chan_o | output | 1 | Selected output channel |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
A trigger, whether a command write or the sequencer pin, is captured on one rising edge, and its first pulse level is due in the cycle right after that edge. Each later level is due exactly its period in cycles after the one before it. done_o and the return to pause are due one cycle after the last level, and a stop takes effect one cycle after its write edge. The bench builds the expected level for every cycle of a burst from the programmed counts and periods. It drives inputs and samples outputs only at falling edges, and it starts comparing at the first falling edge after the capturing edge.

// File: rtl/bpg_pkg.sv
package bpg_pkg;
  typedef enum logic [1:0] {PH_PAUSE, PH_LEAD, PH_MAIN, PH_TAIL} phase_e;

  localparam int A_CTRL  = 0;
  localparam int A_LCNT  = 1;
  localparam int A_MCNT  = 2;
  localparam int A_PER0  = 3;
  localparam int A_CMD   = 7;
  localparam int N_PER   = 4;
  localparam int TAIL_LSB = 8;
endpackage

// File: rtl/bpg_regs.sv
module bpg_regs
  import bpg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 7,
  parameter int TAIL_W = 4,
  parameter int PER_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              en_o,
  output logic              trig_sel_o,
  output logic              chan_mode_o,
  output logic              chan_sel_o,
  output logic              pol_o,
  output logic              pause_lvl_o,
  output logic              pause_hiz_o,
  output logic [CNT_W-1:0]  lead_cnt_o,
  output logic [CNT_W-1:0]  main_cnt_o,
  output logic [TAIL_W-1:0] tail_cnt_o,
  output logic [PER_W-1:0]  lead_hi_o,
  output logic [PER_W-1:0]  lead_lo_o,
  output logic [PER_W-1:0]  main_hi_o,
  output logic [PER_W-1:0]  main_lo_o,
  output logic              sw_trig_o,
  output logic              stop_o
);
  logic [6:0]       ctrl_q;
  logic [PER_W-1:0] per_q [N_PER];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      lead_cnt_o <= '0;
      main_cnt_o <= '0;
      tail_cnt_o <= '0;
    end else if (we_i) begin
      if (addr_i == ADDR_W'(A_CTRL)) ctrl_q <= wdata_i[6:0];
      if (addr_i == ADDR_W'(A_LCNT)) lead_cnt_o <= wdata_i[CNT_W-1:0];
      if (addr_i == ADDR_W'(A_MCNT)) begin
        main_cnt_o <= wdata_i[CNT_W-1:0];
        tail_cnt_o <= wdata_i[TAIL_LSB +: TAIL_W];
      end
    end
  end

  for (genvar g = 0; g < N_PER; g++) begin : g_per
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) per_q[g] <= PER_W'(1);
      else if (we_i && addr_i == ADDR_W'(A_PER0 + g)) per_q[g] <= wdata_i[PER_W-1:0];
    end
  end

  assign lead_hi_o = per_q[0];
  assign lead_lo_o = per_q[1];
  assign main_hi_o = per_q[2];
  assign main_lo_o = per_q[3];

  assign en_o        = ctrl_q[0];
  assign trig_sel_o  = ctrl_q[1];
  assign chan_mode_o = ctrl_q[2];
  assign chan_sel_o  = ctrl_q[3];
  assign pol_o       = ctrl_q[4];
  assign pause_lvl_o = ctrl_q[5];
  assign pause_hiz_o = ctrl_q[6];

  // command bits are strobes, never stored
  assign sw_trig_o = we_i && addr_i == ADDR_W'(A_CMD) && wdata_i[0];
  assign stop_o    = we_i && addr_i == ADDR_W'(A_CMD) && wdata_i[1];
endmodule

// File: rtl/bpg_timer.sv
module bpg_timer #(
  parameter int PER_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PER_W-1:0] load_val_i,
  output logic             expire_o
);
  logic [PER_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = (cnt_q == '0);

  // R3
  count_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/bpg_seq.sv
module bpg_seq
  import bpg_pkg::*;
#(
  parameter int CNT_W  = 7,
  parameter int TAIL_W = 4,
  parameter int PER_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic              en_i,
  input  logic              stop_i,
  input  logic              pol_i,
  input  logic [CNT_W-1:0]  lead_cnt_i,
  input  logic [CNT_W-1:0]  main_cnt_i,
  input  logic [TAIL_W-1:0] tail_cnt_i,
  input  logic [PER_W-1:0]  lead_hi_i,
  input  logic [PER_W-1:0]  lead_lo_i,
  input  logic [PER_W-1:0]  main_hi_i,
  input  logic [PER_W-1:0]  main_lo_i,
  input  logic              expire_i,
  output logic              load_o,
  output logic [PER_W-1:0]  load_val_o,
  output logic              level_o,
  output logic              busy_o,
  output logic              done_o
);
  phase_e           phase_q, phase_d, after_pause, after_lead, after_main, nxt;
  logic             half_q, half_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic             done_q, done_d;

  function automatic logic lvl_of(phase_e ph, logic hf);
    return ~pol_i ^ hf ^ (ph == PH_TAIL);
  endfunction

  // returns cycles minus one for the given half; period 0 acts as 1
  function automatic logic [PER_W-1:0] half_len(phase_e ph, logic hf);
    logic [PER_W-1:0] p;
    if (ph == PH_LEAD) p = lvl_of(ph, hf) ? lead_hi_i : lead_lo_i;
    else               p = lvl_of(ph, hf) ? main_hi_i : main_lo_i;
    return (p == '0) ? '0 : p - 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] cnt_of(phase_e ph);
    case (ph)
      PH_LEAD: return lead_cnt_i;
      PH_MAIN: return main_cnt_i;
      PH_TAIL: return CNT_W'(tail_cnt_i);
      default: return '0;
    endcase
  endfunction

  always_comb begin
    after_main  = (tail_cnt_i != '0) ? PH_TAIL : PH_PAUSE;
    after_lead  = (main_cnt_i != '0) ? PH_MAIN : after_main;
    after_pause = (lead_cnt_i != '0) ? PH_LEAD : after_lead;
    case (phase_q)
      PH_LEAD: nxt = after_lead;
      PH_MAIN: nxt = after_main;
      default: nxt = PH_PAUSE;
    endcase
  end

  always_comb begin
    phase_d    = phase_q;
    half_d     = half_q;
    left_d     = left_q;
    done_d     = 1'b0;
    load_o     = 1'b0;
    load_val_o = '0;
    if (stop_i) begin
      phase_d = PH_PAUSE;
      half_d  = 1'b0;
    end else if (phase_q == PH_PAUSE) begin
      if (trig_i && en_i) begin
        if (after_pause == PH_PAUSE) begin
          done_d = 1'b1;
        end else begin
          phase_d    = after_pause;
          half_d     = 1'b0;
          left_d     = cnt_of(after_pause);
          load_o     = 1'b1;
          load_val_o = half_len(after_pause, 1'b0);
        end
      end
    end else if (expire_i) begin
      if (!half_q) begin
        half_d     = 1'b1;
        load_o     = 1'b1;
        load_val_o = half_len(phase_q, 1'b1);
      end else if (left_q > CNT_W'(1)) begin
        left_d     = left_q - 1'b1;
        half_d     = 1'b0;
        load_o     = 1'b1;
        load_val_o = half_len(phase_q, 1'b0);
      end else if (nxt == PH_PAUSE) begin
        phase_d = PH_PAUSE;
        half_d  = 1'b0;
        done_d  = 1'b1;
      end else begin
        phase_d    = nxt;
        half_d     = 1'b0;
        left_d     = cnt_of(nxt);
        load_o     = 1'b1;
        load_val_o = half_len(nxt, 1'b0);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_PAUSE;
      half_q  <= 1'b0;
      left_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      half_q  <= half_d;
      left_q  <= left_d;
      done_q  <= done_d;
    end
  end

  assign busy_o  = (phase_q != PH_PAUSE);
  assign level_o = busy_o ? lvl_of(phase_q, half_q) : 1'b0;
  assign done_o  = done_q;

  // R2
  phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_PAUSE && !expire_i && !stop_i) |=> $stable(phase_q));
  // R4
  first_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !half_q);
  // R7
  gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_PAUSE && !en_i) |=> phase_q == PH_PAUSE);
  // R8
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (phase_q == PH_PAUSE && !done_q));
  // R9
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && trig_i && !expire_i && !stop_i) |=> ($stable(left_q) && $stable(half_q)));
  // R10
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> phase_q == PH_PAUSE);
endmodule

// File: rtl/burst_pulse_gen.sv
module burst_pulse_gen #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 7,
  parameter int TAIL_W = 4,
  parameter int PER_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              seq_trig_i,
  input  logic              seq_chan_i,
  output logic              pad_o,
  output logic              pad_oe_o,
  output logic              chan_o,
  output logic              busy_o,
  output logic              done_o
);
  logic en, trig_sel, chan_mode, chan_sel, pol, pause_lvl, pause_hiz;
  logic sw_trig, stop, trig, expire, load, level;
  logic [CNT_W-1:0]  lead_cnt, main_cnt;
  logic [TAIL_W-1:0] tail_cnt;
  logic [PER_W-1:0]  lead_hi, lead_lo, main_hi, main_lo, load_val;

  bpg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .TAIL_W(TAIL_W), .PER_W(PER_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .en_o(en), .trig_sel_o(trig_sel), .chan_mode_o(chan_mode), .chan_sel_o(chan_sel),
    .pol_o(pol), .pause_lvl_o(pause_lvl), .pause_hiz_o(pause_hiz),
    .lead_cnt_o(lead_cnt), .main_cnt_o(main_cnt), .tail_cnt_o(tail_cnt),
    .lead_hi_o(lead_hi), .lead_lo_o(lead_lo), .main_hi_o(main_hi), .main_lo_o(main_lo),
    .sw_trig_o(sw_trig), .stop_o(stop)
  );

  assign trig = trig_sel ? seq_trig_i : sw_trig;

  bpg_timer #(.PER_W(PER_W)) u_timer (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(load_val), .expire_o(expire)
  );

  bpg_seq #(.CNT_W(CNT_W), .TAIL_W(TAIL_W), .PER_W(PER_W)) u_seq (
    .clk_i, .rst_ni,
    .trig_i(trig), .en_i(en), .stop_i(stop), .pol_i(pol),
    .lead_cnt_i(lead_cnt), .main_cnt_i(main_cnt), .tail_cnt_i(tail_cnt),
    .lead_hi_i(lead_hi), .lead_lo_i(lead_lo), .main_hi_i(main_hi), .main_lo_i(main_lo),
    .expire_i(expire), .load_o(load), .load_val_o(load_val),
    .level_o(level), .busy_o(busy_o), .done_o(done_o)
  );

  assign pad_o    = busy_o ? level : (pause_hiz ? 1'b0 : pause_lvl);
  assign pad_oe_o = busy_o | ~pause_hiz;
  assign chan_o   = chan_mode ? seq_chan_i : chan_sel;
endmodule

// File: tb/sim_burst_pulse_gen.sv
module sim_burst_pulse_gen;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       pol;
    logic [6:0] lc;
    logic [6:0] mc;
    logic [3:0] tc;
    logic [7:0] lh, ll, mh, ml;
  } tv_t;

  localparam int N_TV = 6;
  localparam tv_t TV [N_TV] = '{
    '{1'b0, 7'd2,   7'd1,   4'd1,  8'd2, 8'd1, 8'd1, 8'd3},
    '{1'b1, 7'd1,   7'd2,   4'd2,  8'd1, 8'd2, 8'd2, 8'd1},
    '{1'b0, 7'd0,   7'd3,   4'd0,  8'd4, 8'd4, 8'd1, 8'd1},
    '{1'b1, 7'd3,   7'd0,   4'd2,  8'd3, 8'd1, 8'd1, 8'd2},
    '{1'b0, 7'd1,   7'd1,   4'd0,  8'd0, 8'd0, 8'd5, 8'd2},
    '{1'b0, 7'd127, 7'd127, 4'd15, 8'd1, 8'd1, 8'd1, 8'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [2:0] addr = '0;
  logic [15:0] wdata = '0;
  logic seq_trig = 1'b0;
  logic seq_chan = 1'b0;
  logic pad, pad_oe, chan, busy, done;

  int total = 0;
  int bad = 0;
  logic finished = 1'b0;
  logic exp_lvl [4096];
  int exp_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_pulse_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .seq_trig_i(seq_trig), .seq_chan_i(seq_chan),
    .pad_o(pad), .pad_oe_o(pad_oe), .chan_o(chan), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  function automatic logic [15:0] ctl(logic en, logic tsel, logic cmode, logic csel,
                                      logic pol, logic plvl, logic phiz);
    return {9'd0, phiz, plvl, pol, csel, cmode, tsel, en};
  endfunction

  task automatic setup(input tv_t v, input logic [15:0] c);
    wr(3'd0, c | {11'd0, v.pol, 4'd0});
    wr(3'd1, {9'd0, v.lc});
    wr(3'd2, {4'd0, v.tc, 1'b0, v.mc});
    wr(3'd3, {8'd0, v.lh});
    wr(3'd4, {8'd0, v.ll});
    wr(3'd5, {8'd0, v.mh});
    wr(3'd6, {8'd0, v.ml});
  endtask

  // expected level per cycle, derived from the requirements
  task automatic build(input tv_t v);
    exp_n = 0;
    for (int ph = 0; ph < 3; ph++) begin
      int cnt = (ph == 0) ? int'(v.lc) : (ph == 1) ? int'(v.mc) : int'(v.tc);
      for (int p = 0; p < cnt; p++)
        for (int h = 0; h < 2; h++) begin
          logic lvl = (~v.pol) ^ h[0] ^ (ph == 2);
          int len = lvl ? ((ph == 0) ? int'(v.lh) : int'(v.mh))
                        : ((ph == 0) ? int'(v.ll) : int'(v.ml));
          if (len == 0) len = 1;
          for (int c = 0; c < len; c++) begin
            exp_lvl[exp_n] = lvl;
            exp_n++;
          end
        end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 oe", pad_oe, 1);
    chk("R1 pad", pad, 0);
    chk("R1 chan", chan, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table of bursts: R2 R3 R4 R9 R10
    for (int t = 0; t < N_TV; t++) begin
      setup(TV[t], ctl(1, 0, 0, 0, 0, 0, 0));
      build(TV[t]);
      wr(3'd7, 16'h0001);
      for (int i = 0; i < exp_n; i++) begin
        if (i > 0) @(negedge clk);
        chk($sformatf("R3 R4 tv%0d cyc%0d pad", t, i), pad, exp_lvl[i]);
        chk("R9 busy during burst", busy, 1);
        chk("R5 oe during burst", pad_oe, 1);
      end
      @(negedge clk);
      chk($sformatf("R2 tv%0d end busy", t), busy, 0);
      chk($sformatf("R10 tv%0d done", t), done, 1);
      chk("R5 pause pad", pad, 0);
      @(negedge clk);
      chk("R10 done single", done, 0);
    end

    // R7 disabled trigger
    setup(TV[0], ctl(0, 0, 0, 0, 0, 0, 0));
    wr(3'd7, 16'h0001);
    for (int i = 0; i < 3; i++) begin
      chk("R7 busy stays low", busy, 0);
      chk("R7 pad at pause", pad, 0);
      @(negedge clk);
    end

    // R6 sequencer trigger mode
    setup('{1'b0, 7'd1, 7'd0, 4'd0, 8'd2, 8'd2, 8'd1, 8'd1}, ctl(1, 1, 0, 0, 0, 0, 0));
    wr(3'd7, 16'h0001);
    chk("R6 command ignored", busy, 0);
    seq_trig = 1'b1;
    @(negedge clk);
    seq_trig = 1'b0;
    chk("R6 seq trigger busy", busy, 1);
    chk("R6 seq trigger pad", pad, 1);
    repeat (4) @(negedge clk);
    chk("R6 seq burst end", busy, 0);
    chk("R10 seq done", done, 1);

    // R8 abort, pause level high
    setup('{1'b0, 7'd0, 7'd100, 4'd3, 8'd1, 8'd1, 8'd4, 8'd4}, ctl(1, 0, 0, 0, 0, 1, 0));
    wr(3'd7, 16'h0001);
    chk("R8 started", busy, 1);
    repeat (5) @(negedge clk);
    wr(3'd7, 16'h0002);
    chk("R8 busy after stop", busy, 0);
    chk("R8 pad at pause", pad, 1);
    chk("R8 oe at pause", pad_oe, 1);
    chk("R8 no done", done, 0);
    @(negedge clk);
    chk("R8 no done later", done, 0);
    chk("R8 stays idle", busy, 0);

    // R9 retrigger while busy is ignored
    setup('{1'b0, 7'd1, 7'd0, 4'd0, 8'd3, 8'd3, 8'd1, 8'd1}, ctl(1, 0, 0, 0, 0, 0, 0));
    wr(3'd7, 16'h0001);
    wr(3'd7, 16'h0001);
    begin
      int k = 0;
      while (busy && k < 20) begin
        k++;
        @(negedge clk);
      end
      chk("R9 remaining busy cycles", k, 4);
    end
    chk("R10 done after retrigger", done, 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R9 no second burst", busy, 0);
    end

    // R5 high impedance pause
    setup('{1'b0, 7'd1, 7'd0, 4'd0, 8'd1, 8'd1, 8'd1, 8'd1}, ctl(1, 0, 0, 0, 0, 1, 1));
    chk("R5 hiz oe", pad_oe, 0);
    chk("R5 hiz pad", pad, 0);
    wr(3'd7, 16'h0001);
    chk("R5 burst oe", pad_oe, 1);
    chk("R5 burst pad high", pad, 1);
    @(negedge clk);
    chk("R5 burst pad low", pad, 0);
    @(negedge clk);
    chk("R5 back to hiz", pad_oe, 0);
    chk("R10 hiz done", done, 1);

    // R10 all counts zero
    setup('{1'b0, 7'd0, 7'd0, 4'd0, 8'd1, 8'd1, 8'd1, 8'd1}, ctl(1, 0, 0, 0, 0, 0, 0));
    wr(3'd7, 16'h0001);
    chk("R10 empty busy", busy, 0);
    chk("R10 empty done", done, 1);
    @(negedge clk);
    chk("R10 empty done once", done, 0);

    // R11 channel select
    wr(3'd0, ctl(1, 0, 0, 1, 0, 0, 0));
    seq_chan = 1'b0;
    chk("R11 register channel", chan, 1);
    wr(3'd0, ctl(1, 0, 1, 1, 0, 0, 0));
    chk("R11 seq channel 0", chan, 0);
    seq_chan = 1'b1;
    @(negedge clk);
    chk("R11 seq channel 1", chan, 1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule